// File: doc/BRIEF.md
# Microsecond One-Shot Delay Timer

This block turns a delay expressed in microseconds into a count of ticks from a clock enable that pulses about 1.193182 million times per second, then runs that count down once. A load strobe captures a 32-bit microsecond value. The hardware first multiplies the value by 1193182 at full width. It then divides by one million with a sequential restoring divider and keeps only the integer part. The result is clamped to 16 bits and placed in a down-counter.

The counter decrements on each tick enable. It never reloads by itself. When it reaches zero, a sticky done flag rises. That flag is also presented as bit 5 of an 8-bit status byte, so a sequencer or polling loop can wait on it. A busy output covers the time the divider needs. An overflow flag reports when the quotient did not fit in 16 bits.

Top module: `usec_delay_timer`

## Requirements
- R1: After a load of x microseconds, the counter is loaded with floor(x·1193182 / 1000000), computed at full product width before dividing. For example, 10000 gives 11931 and 200 gives 238.
- R2: A quotient above 65535 loads 65535 and sets `ovf_o`. A quotient of 65535 or less loads exactly and clears `ovf_o`. `ovf_o` updates when the counter is loaded.
- R3: `busy_o` is high in the cycle after a load strobe. It stays high until the counter takes its new value, for at most PROD_W+1 cycles, where PROD_W is the product width (53 by default).
- R4: While not busy and not done, each cycle with `tick_i` high lowers `count_o` by one. Ticks while `busy_o` is high do not change `count_o`.
- R5: `done_o` rises on the tick where `count_o` goes from 1 to 0. After that, `done_o` stays high and `count_o` stays 0 under further ticks until the next load.
- R6: A load strobe clears `done_o` in the following cycle.
- R7: When the computed reload value is zero, `done_o` is high in the same cycle the counter is loaded, with no tick needed.
- R8: `status_o` bit 5 equals `done_o`, and every other status bit is 0.
- R9: A load strobe while busy abandons the computation in progress. The counter receives the value for the newest request.
- R10: After reset, `count_o`, `done_o`, `busy_o`, `ovf_o` and `status_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe; starts a new delay request |
| usec_i | input | 32 | Delay in microseconds, sampled with `load_i` |
| tick_i | input | 1 | Tick enable at about 1.193182 MHz |
| busy_o | output | 1 | Reload value is being computed |
| done_o | output | 1 | Sticky completion flag |
| ovf_o | output | 1 | Last reload value was clamped to 65535 |
| count_o | output | 16 | Current counter value |
| status_o | output | 8 | Polled status byte, done at bit 5 |

## Verification
The bench uses the default parameters: a 32-bit microsecond input, a 53-bit product and a 53-step divider. With these values, inputs near 54925 fall on both sides of the 16-bit limit, and the largest inputs produce quotients in the billions. Both the exact and the clamped paths are therefore reachable. Small inputs keep reload values in the hundreds, so full countdowns, zero reloads and ticks held through the busy window all fit easily within the run.

// File: rtl/usdly_pkg.sv
package usdly_pkg;

    localparam int CNT_W    = 16;
    localparam int TICK_HZ  = 1193182;
    localparam int US_PER_S = 1000000;
    localparam int HZ_W     = $clog2(TICK_HZ + 1);
    localparam int SC_W     = $clog2(US_PER_S + 1);
    localparam int DONE_BIT = 5;
    localparam int STAT_W   = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t value;
        logic ovf;
    } reload_t;

    // Clamp a wide quotient (zero-extended to 64 bits) into the counter width.
    function automatic reload_t clamp_quotient(input logic [63:0] quo);
        reload_t r;
        if (quo > 64'(cnt_t'('1))) begin
            r.value = '1;
            r.ovf   = 1'b1;
        end else begin
            r.value = quo[CNT_W-1:0];
            r.ovf   = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/usdly_scale.sv
module usdly_scale #(
    parameter int US_W   = 32,
    parameter int HZ_W   = 21,
    parameter int FACTOR = 1193182,
    localparam int OUT_W = US_W + HZ_W
) (
    input  logic [US_W-1:0]  usec_i,
    output logic [OUT_W-1:0] product_o
);
    // Full-width product so the later division loses nothing.
    always_comb begin
        product_o = OUT_W'(usec_i) * OUT_W'(FACTOR);
    end
endmodule

// File: rtl/usdly_divider.sv
module usdly_divider #(
    parameter int N_W     = 53,
    parameter int D_W     = 20,
    parameter int DIVISOR = 1000000,
    localparam int STEP_W = $clog2(N_W + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [N_W-1:0] dividend_i,
    output logic           run_o,
    output logic           fin_o,
    output logic [N_W-1:0] quot_o
);
    logic [D_W-1:0]    rem_q;
    logic [N_W-1:0]    quo_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic              fin_q;

    logic [D_W:0]      shifted;
    logic [D_W:0]      diff;
    logic              take;
    logic [D_W-1:0]    rem_nxt;

    // One restoring step: bring in the next dividend bit, subtract if it fits.
    always_comb begin
        shifted = {rem_q, quo_q[N_W-1]};
        take    = shifted >= (D_W+1)'(DIVISOR);
        diff    = shifted - (D_W+1)'(DIVISOR);
        rem_nxt = take ? diff[D_W-1:0] : shifted[D_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
            step_q <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
        end else if (start_i) begin
            run_q  <= 1'b1;
            fin_q  <= 1'b0;
            step_q <= STEP_W'(N_W);
            rem_q  <= '0;
            quo_q  <= dividend_i;
        end else if (run_q) begin
            rem_q  <= rem_nxt;
            quo_q  <= {quo_q[N_W-2:0], take};
            step_q <= step_q - 1'b1;
            if (step_q == STEP_W'(1)) begin
                run_q <= 1'b0;
                fin_q <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign run_o  = run_q;
    assign fin_o  = fin_q;
    assign quot_o = quo_q;
endmodule

// File: rtl/usdly_count.sv
module usdly_count
    import usdly_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear_i,
    input  logic    load_i,
    input  reload_t value_i,
    input  logic    tick_i,
    output cnt_t    count_o,
    output logic    done_o,
    output logic    ovf_o
);
    cnt_t count_q;
    logic done_q;
    logic ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (clear_i) begin
            done_q  <= 1'b0;
        end else if (load_i) begin
            count_q <= value_i.value;
            done_q  <= (value_i.value == '0);
            ovf_q   <= value_i.ovf;
        end else if (tick_i && !done_q && count_q != '0) begin
            count_q <= count_q - 1'b1;
            if (count_q == cnt_t'(1)) begin
                done_q <= 1'b1;
            end
        end
    end

    assign count_o = count_q;
    assign done_o  = done_q;
    assign ovf_o   = ovf_q;
endmodule

// File: rtl/usec_delay_timer.sv
module usec_delay_timer
    import usdly_pkg::*;
#(
    parameter int US_W    = 32,
    localparam int PROD_W = US_W + HZ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [US_W-1:0]   usec_i,
    input  logic              tick_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ovf_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [STAT_W-1:0] status_o
);
    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] quotient;
    logic              div_run;
    logic              div_fin;
    reload_t           reload;
    logic              tick_gated;

    usdly_scale #(
        .US_W   (US_W),
        .HZ_W   (HZ_W),
        .FACTOR (TICK_HZ)
    ) u_scale (
        .usec_i    (usec_i),
        .product_o (product)
    );

    usdly_divider #(
        .N_W     (PROD_W),
        .D_W     (SC_W),
        .DIVISOR (US_PER_S)
    ) u_div (
        .clk        (clk),
        .rst        (rst),
        .start_i    (load_i),
        .dividend_i (product),
        .run_o      (div_run),
        .fin_o      (div_fin),
        .quot_o     (quotient)
    );

    always_comb begin
        reload = clamp_quotient(64'(quotient));
    end

    assign busy_o     = div_run | div_fin;
    assign tick_gated = tick_i & ~busy_o;

    usdly_count u_count (
        .clk     (clk),
        .rst     (rst),
        .clear_i (load_i),
        .load_i  (div_fin),
        .value_i (reload),
        .tick_i  (tick_gated),
        .count_o (count_o),
        .done_o  (done_o),
        .ovf_o   (ovf_o)
    );

    // Status byte: only the completion bit is populated.
    always_comb begin
        status_o           = '0;
        status_o[DONE_BIT] = done_o;
    end
endmodule

// File: rtl/usec_delay_timer_chk.sv
module usec_delay_timer_chk #(
    parameter int PROD_W = 53
) (
    input logic        clk,
    input logic        rst,
    input logic        load_i,
    input logic        tick_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        ovf_o,
    input logic [15:0] count_o
);
    logic [15:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) busy_len <= '0;
        else if (load_i)    busy_len <= 16'd1;
        else                busy_len <= busy_len + 16'd1;
    end

    p_busy_bound_r3: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (busy_len <= 16'(PROD_W + 1)));

    p_load_clears_r6: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (!done_o && busy_o));

    p_done_zero_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (count_o == 16'd0));

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !load_i) |=> done_o);

    p_tick_step_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !busy_o && !load_i && !done_o && count_o != 16'd0)
        |=> (count_o == $past(count_o) - 16'd1));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !busy_o && !load_i) |=> $stable(count_o));

    p_sat_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && ovf_o) |-> (count_o == 16'hFFFF));
endmodule

bind usec_delay_timer usec_delay_timer_chk #(.PROD_W(PROD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .tick_i  (tick_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .ovf_o   (ovf_o),
    .count_o (count_o)
);

// File: tb/usec_delay_timer_bench.sv
module usec_delay_timer_bench;
    localparam int PROD_W = 53;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [31:0] usec_i = '0;
    logic        tick_i = 1'b0;
    logic        busy_o, done_o, ovf_o;
    logic [15:0] count_o;
    logic [7:0]  status_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    usec_delay_timer u_usec_delay_timer (
        .clk(clk), .rst(rst), .load_i(load_i), .usec_i(usec_i), .tick_i(tick_i),
        .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o),
        .count_o(count_o), .status_o(status_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic longint unsigned exp_quot(input logic [31:0] x);
        longint unsigned p;
        p = longint'(x) * 64'd1193182;
        return p / 64'd1000000;
    endfunction

    function automatic logic [15:0] exp_reload(input logic [31:0] x);
        longint unsigned q = exp_quot(x);
        return (q > 64'd65535) ? 16'hFFFF : q[15:0];
    endfunction

    function automatic logic exp_ovf(input logic [31:0] x);
        return exp_quot(x) > 64'd65535;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_load(input logic [31:0] x);
        @(negedge clk);
        load_i = 1'b1;
        usec_i = x;
        @(negedge clk);
        load_i = 1'b0;
        check(busy_o == 1'b1, "R3", "busy after load", busy_o, 1);
        check(done_o == 1'b0, "R6", "done cleared by load", done_o, 0);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
        end
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic load_and_check(input logic [31:0] x);
        int n;
        start_load(x);
        wait_idle(n);
        check(n <= PROD_W + 1 && n >= 1, "R3", "busy length", n, PROD_W + 1);
        check(count_o == exp_reload(x), "R1", "reload value", count_o, exp_reload(x));
        check(ovf_o == exp_ovf(x), "R2", "overflow flag", ovf_o, exp_ovf(x));
    endtask

    initial begin
        int n;
        logic [15:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(count_o == 0 && done_o == 0 && busy_o == 0 && ovf_o == 0 && status_o == 0,
              "R10", "reset state", {count_o, done_o, busy_o, ovf_o}, 0);

        load_and_check(32'd10000);
        check(count_o == 16'd11931, "R1", "10000 us", count_o, 11931);

        load_and_check(32'd200);
        check(count_o == 16'd238, "R1", "200 us", count_o, 238);
        ticks(237);
        check(count_o == 16'd1 && done_o == 0, "R4", "count after 237 ticks", count_o, 1);
        check(status_o == 8'h00, "R8", "status before done", status_o, 0);
        ticks(1);
        check(done_o == 1 && count_o == 0, "R5", "done at zero", done_o, 1);
        check(status_o == 8'h20, "R8", "status at done", status_o, 32);
        ticks(5);
        check(done_o == 1 && count_o == 0, "R5", "sticky done", count_o, 0);

        load_and_check(32'd0);
        check(done_o == 1 && count_o == 0, "R7", "zero reload done", done_o, 1);
        load_and_check(32'd1);
        check(done_o == 0 && count_o == 16'd1, "R6", "done low after reload 1", done_o, 0);

        load_and_check(32'd60000);
        check(count_o == 16'hFFFF && ovf_o, "R2", "saturate 60000", count_o, 65535);
        load_and_check(32'd54925);
        check(count_o == 16'd65535 && !ovf_o, "R2", "edge below limit", ovf_o, 0);
        load_and_check(32'd54926);
        check(ovf_o == 1'b1, "R2", "edge above limit", ovf_o, 1);
        load_and_check(32'hFFFF_FFFF);
        check(ovf_o == 1'b1, "R2", "max input", ovf_o, 1);
        load_and_check(32'd200);
        check(ovf_o == 1'b0, "R2", "overflow cleared", ovf_o, 0);

        // R4: ticks held high across the busy window are ignored
        start_load(32'd100);
        tick_i = 1'b1;
        while (busy_o) @(negedge clk);
        tick_i = 1'b0;
        check(count_o == 16'd119, "R4", "ticks ignored while busy", count_o, 119);

        // R9: restart mid-computation
        start_load(32'd500);
        repeat (5) @(negedge clk);
        load_and_check(32'd100);
        check(count_o == 16'd119, "R9", "restart takes new value", count_o, 119);

        for (int it = 0; it < 60; it++) begin
            logic [31:0] x;
            int mode = int'($urandom % 4);
            case (mode)
                0: x = $urandom % 300;
                1: x = $urandom;
                2: x = 32'd54900 + ($urandom % 50);
                default: x = $urandom % 60000;
            endcase
            load_and_check(x);
            r = exp_reload(x);
            if (mode == 0) begin
                if (r == 0) begin
                    check(done_o == 1, "R7", "random zero reload", done_o, 1);
                end else begin
                    ticks(int'(r) - 1);
                    check(done_o == 0 && count_o == 1, "R4", "random pre-zero", count_o, 1);
                    ticks(1);
                    check(done_o == 1 && count_o == 0, "R5", "random done", done_o, 1);
                end
            end else if (mode == 3) begin
                n = int'($urandom % 20);
                if (int'(r) > n) begin
                    ticks(n);
                    check(count_o == r - 16'(n), "R4", "random partial count", count_o, r - 16'(n));
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule